// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fetch Redirection

This block gathers interrupt requests from a set of peripheral sources and presents a single IRQ line to a processor. Each request is edge-detected into a sticky pending bit. A mask register decides which pending sources may compete. The lowest-index unmasked pending source is captured into a one-hot service register, and IRQ stays asserted while that register is non-zero.

The block sits on the processor's instruction fetch address path, in front of boot memory. In vectored mode, a fetch at the IRQ exception address (byte address 0x18) is steered to the winning source's own slot word. The slot word typically holds a jump to that source's handler. In non-vectored mode, or when nothing is in service, the fetch address passes through untouched. Software then scans the service register from bit 0 upward and uses bit n as a handler-table offset of 4×n.

Slots are one word apart in groups of six, and each group spans eight words. That leaves two unused slot words after every group.

Source 4 is shared by several external pins. The pins have their own sub-pending state, which is held outside this block. Its pending bit cannot be cleared while that sub-pending state is still reported busy.

Top module: `ifc_vec_ctrl`

## Requirements
- R1: After reset, irq_o is low, the control register reads 0 (non-vectored), the mask reads all ones over the source bits (every source blocked), and pending and service read 0.
- R2: A pending bit is set on a 0→1 transition of its request input and stays set until cleared. A request input held high after a clear does not set it again.
- R3: A masked source may be pending but is never captured into the service register. If no unmasked source is pending, irq_o stays low.
- R4: When the service register is empty, the lowest-index source that is pending and unmasked is captured as a one-hot value on the next clock. irq_o is high exactly while the service register is non-zero.
- R5: While the service register is non-zero, it holds its value. It is not displaced by newly pending lower-index sources or by mask changes.
- R6: A write to register select 3 clears every pending bit and service bit whose data bit is 1. Bits written 0 are untouched. A new winner is captured on the clock after the service register becomes empty.
- R7: With control bit 0 set and a source in service, a fetch at byte address 0x18 is output as that source's slot address.
- R8: Source n maps to slot byte address 0x20 + 0x20·(n div 6) + 4·(n mod 6). The reserved words 0x38, 0x3C, 0x58 and 0x5C are never produced.
- R9: Any other fetch address passes through unchanged, including the FIQ vector 0x1C. All fetches pass through in non-vectored mode or when nothing is in service.
- R10: While shared_sub_busy_i is high, a clear of bit 4 has no effect on source 4's pending or service bit.
- R11: If a rising edge on a request and a clear of the same bit occur in the same cycle, the pending bit ends up set.
- R12: The register selects are: 0 for control (bit 0 = vectored enable), 1 for mask (1 = blocked), 2 for pending (read-only, writes ignored), and 3 for service (reads the one-hot service register, writes clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | N_SRC | Peripheral request lines |
| shared_sub_busy_i | input | 1 | Sub-pending state of the shared external source still set |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for reg_sel_i |
| irq_o | output | 1 | Interrupt request to processor |
| cpu_fetch_addr_i | input | AW | Processor instruction fetch byte address |
| mem_fetch_addr_o | output | AW | Fetch byte address presented to boot memory |

## Verification
Simultaneous requests on separated indices show whether the lowest index wins. A later lower-index request and a mask change during service show whether the winner is truly frozen. Sweeping winners across each group boundary (sources 5/6, 11/12, 17/18 and the last source) distinguishes a correct slot formula from a plain 4·n offset, which would land on reserved words. Fetches at 0x18, 0x1C and a slot address in both modes separate redirection from pass-through. Clear writes with the shared-source busy input high, and a clear coinciding with a fresh edge, exercise the two clear-ordering rules.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  parameter logic [31:0] IRQ_VEC       = 32'h18;
  parameter logic [31:0] FIQ_VEC       = 32'h1C;
  parameter logic [31:0] SLOT_BASE     = 32'h20;
  parameter int unsigned SLOTS_PER_GRP = 6;
  parameter int unsigned GRP_WORDS     = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PEND = 2'd2,
    SEL_SRV  = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] slot_addr(input int unsigned n);
    return SLOT_BASE + 32'(4 * GRP_WORDS * (n / SLOTS_PER_GRP))
                     + 32'(4 * (n % SLOTS_PER_GRP));
  endfunction
endpackage

// File: rtl/ifc_pend_latch.sv
module ifc_pend_latch #(
  parameter int unsigned N = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q, pend_q, rise;

  assign rise   = src_i & ~src_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise;  // edge beats clear
    end
  end

  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
  a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~rise) != '0) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & rise) != '0) |=> ((pend_q & $past(clr_i & rise)) == $past(clr_i & rise)));
endmodule

// File: rtl/ifc_prio_pick.sv
module ifc_prio_pick #(
  parameter int unsigned N  = 26,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_i_o,
  output logic          any_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant_o[g]  = req_i[g] & ~taken[g];
    assign taken[g+1]  = taken[g] | req_i[g];
  end

  assign any_o = taken[N];

  always_comb begin
    idx_i_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_i_o = idx_i_o | IW'(i);
    a_r4_grant_onehot: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/ifc_regs.sv
module ifc_regs
  import ifc_pkg::*;
#(
  parameter int unsigned N  = 26,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  service_i,
  output logic          vect_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata_o
);
  logic         vect_q;
  logic [N-1:0] mask_q;
  reg_sel_e     sel;
  logic         unused_wbits;

  assign sel          = reg_sel_e'(sel_i);
  assign unused_wbits = ^wdata_i[DW-1:N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vect_q <= 1'b0;
      mask_q <= '1;
    end else if (we_i) begin
      if (sel == SEL_CTRL) vect_q <= wdata_i[0];
      if (sel == SEL_MASK) mask_q <= wdata_i[N-1:0];
    end
  end

  assign clr_o  = (we_i && sel == SEL_SRV) ? wdata_i[N-1:0] : '0;
  assign vect_o = vect_q;
  assign mask_o = mask_q;

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_o = DW'(vect_q);
      SEL_MASK: rdata_o = DW'(mask_q);
      SEL_PEND: rdata_o = DW'(pend_i);
      default:  rdata_o = DW'(service_i);
    endcase
  end

  a_r12_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_CTRL) |=> (vect_q == $past(wdata_i[0])));
  a_r12_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == SEL_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/ifc_fetch_remap.sv
module ifc_fetch_remap
  import ifc_pkg::*;
#(
  parameter int unsigned N  = 26,
  parameter int unsigned AW = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          vect_i,
  input  logic          active_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] slot_tbl [N];
  logic          hit;
  logic [AW-1:0] word_off;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot_tbl[g] = AW'(slot_addr(g));
  end

  assign hit      = vect_i && active_i && (addr_i == AW'(IRQ_VEC));
  assign addr_o   = hit ? slot_tbl[idx_i] : addr_i;
  assign word_off = (addr_o - AW'(SLOT_BASE)) >> 2;

  always_comb begin
    if (hit) begin
      a_r8_no_reserved_slot: assert ((word_off % AW'(GRP_WORDS)) < AW'(SLOTS_PER_GRP));
    end
    if (addr_i == AW'(FIQ_VEC)) begin
      a_r9_fiq_untouched: assert (addr_o == addr_i);
    end
  end
endmodule

// File: rtl/ifc_vec_ctrl.sv
module ifc_vec_ctrl
  import ifc_pkg::*;
#(
  parameter int unsigned N_SRC      = 26,
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned SHARED_IDX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic             shared_sub_busy_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o,
  input  logic [AW-1:0]    cpu_fetch_addr_i,
  output logic [AW-1:0]    mem_fetch_addr_o
);
  localparam int unsigned IW = $clog2(N_SRC);
  localparam logic [N_SRC-1:0] SHARED_BIT = N_SRC'(1) << SHARED_IDX;

  logic [N_SRC-1:0] pend, mask, clr_raw, clr_eff, grant, service_q, service_d;
  logic [IW-1:0]    srv_idx, grant_idx_unused;
  logic             vect, grant_any_unused;

  // shared source keeps its pending bit until its sub-pending state is gone
  assign clr_eff = clr_raw & ~(shared_sub_busy_i ? SHARED_BIT : '0);

  ifc_regs #(.N(N_SRC), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .pend_i    (pend),
    .service_i (service_q),
    .vect_o    (vect),
    .mask_o    (mask),
    .clr_o     (clr_raw),
    .rdata_o   (reg_rdata_o)
  );

  ifc_pend_latch #(.N(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src_i),
    .clr_i  (clr_eff),
    .pend_o (pend)
  );

  ifc_prio_pick #(.N(N_SRC), .IW(IW)) u_pick (
    .req_i   (pend & ~mask & ~clr_eff),
    .grant_o (grant),
    .idx_i_o (grant_idx_unused),
    .any_o   (grant_any_unused)
  );

  assign service_d = (service_q != '0) ? (service_q & ~clr_eff) : grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) service_q <= '0;
    else         service_q <= service_d;
  end

  always_comb begin
    srv_idx = '0;
    for (int i = 0; i < N_SRC; i++)
      if (service_q[i]) srv_idx = srv_idx | IW'(i);
  end

  assign irq_o = (service_q != '0);

  ifc_fetch_remap #(.N(N_SRC), .AW(AW), .IW(IW)) u_remap (
    .vect_i   (vect),
    .active_i (irq_o),
    .idx_i    (srv_idx),
    .addr_i   (cpu_fetch_addr_i),
    .addr_o   (mem_fetch_addr_o)
  );

  a_r4_service_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(service_q));
  a_r5_service_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (service_q != '0 && (service_q & clr_eff) == '0) |=> $stable(service_q));
  a_r3_masked_never_won: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (service_q == '0) |=> ((service_q & $past(mask)) == '0));
  a_r7_remap_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vect && irq_o && cpu_fetch_addr_i == AW'(IRQ_VEC)) |-> (mem_fetch_addr_o != cpu_fetch_addr_i));
  a_r10_shared_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_sub_busy_i && pend[SHARED_IDX]) |=> pend[SHARED_IDX]);
endmodule

// File: tb/ifc_vec_ctrl_tb.sv
`timescale 1ns/1ps
module ifc_vec_ctrl_tb;
  localparam int N = 26;
  localparam logic [31:0] ALLSRC = (32'd1 << N) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        busy = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] faddr = 32'h0;
  logic [31:0] maddr;

  int n_vec = 0, n_bad = 0, cyc_cnt = 0;

  always #2 clk = ~clk;

  ifc_vec_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .shared_sub_busy_i(busy),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .cpu_fetch_addr_i(faddr), .mem_fetch_addr_o(maddr)
  );

  // behavioural reference model
  logic [31:0] m_pend, m_prev, m_srv, m_mask;
  logic        m_vect;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_prev = 0; m_srv = 0; m_mask = ALLSRC; m_vect = 0;
    end else begin
      logic [31:0] clr, rise, np, ns;
      clr  = (we && sel == 2'd3) ? (wdata & ALLSRC) : 0;
      if (busy) clr[4] = 1'b0;
      rise = 32'(src) & ~m_prev;
      np = (m_pend & ~clr) | rise;
      ns = 0;
      if (m_srv != 0) ns = m_srv & ~clr;
      else begin
        for (int i = 0; i < N; i++)
          if (ns == 0 && m_pend[i] && !m_mask[i] && !clr[i]) ns = 32'd1 << i;
      end
      if (we && sel == 2'd0) m_vect = wdata[0];
      if (we && sel == 2'd1) m_mask = wdata & ALLSRC;
      m_pend = np; m_srv = ns; m_prev = 32'(src);
    end
  end

  function automatic logic [31:0] slot_of(int n);
    return 32'h20 + 32'(32 * (n / 6)) + 32'(4 * (n % 6));
  endfunction

  function automatic logic [31:0] exp_fetch();
    if (m_vect && m_srv != 0 && faddr == 32'h18)
      for (int i = 0; i < N; i++) if (m_srv[i]) return slot_of(i);
    return faddr;
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (sel)
      2'd0: return {31'd0, m_vect};
      2'd1: return m_mask;
      2'd2: return m_pend;
      default: return m_srv;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc_cnt++;
      if (rst_n) begin
        chk("R4 irq_o", {31'd0, irq}, {31'd0, (m_srv != 0)});
        chk("R7/R9 fetch", maddr, exp_fetch());
        chk("R12 rdata", rdata, exp_rdata());
      end
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] s, logic [31:0] exp);
    sel = s; #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic fetch_chk(string tag, logic [31:0] a, logic [31:0] exp);
    faddr = a; #0.5;
    chk(tag, maddr, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc_cnt > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc_cnt);
        finish_run();
      end
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd_chk("R1 ctrl", 2'd0, 32'd0);
    rd_chk("R1 mask", 2'd1, ALLSRC);
    rd_chk("R1 pend", 2'd2, 32'd0);
    rd_chk("R1 srv", 2'd3, 32'd0);

    // R2/R3: masked source latches but does not win; level hold does not re-set
    src[7] = 1'b1; tick(3);
    rd_chk("R2 pend on edge", 2'd2, 32'h80);
    chk("R3 masked no irq", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h80); tick(2);
    rd_chk("R2 level no reset", 2'd2, 32'd0);
    src[7] = 1'b0; tick(1);

    // R12: pending register is read-only
    src[7] = 1'b1; tick(2);
    wr(2'd2, 32'h0); tick(1);
    rd_chk("R12 pend write ignored", 2'd2, 32'h80);
    wr(2'd3, 32'h80); src[7] = 1'b0; tick(1);

    // R4: lowest index wins
    wr(2'd1, 32'h0);
    src[3] = 1'b1; src[9] = 1'b1; tick(3);
    rd_chk("R4 winner bit3", 2'd3, 32'h8);
    chk("R4 irq high", {31'd0, irq}, 32'd1);
    fetch_chk("R9 nonvect pass", 32'h18, 32'h18);
    wr(2'd0, 32'h1); tick(1);
    fetch_chk("R7 remap src3", 32'h18, 32'h2C);
    fetch_chk("R9 fiq pass", 32'h1C, 32'h1C);
    fetch_chk("R9 slot pass", 32'h20, 32'h20);

    // R5: frozen against lower index and mask change
    src[1] = 1'b1; tick(3);
    rd_chk("R5 not displaced", 2'd3, 32'h8);
    wr(2'd1, 32'h8); tick(2);
    rd_chk("R5 mask no effect", 2'd3, 32'h8);
    wr(2'd1, 32'h0);

    // R6: clear and re-arbitrate
    wr(2'd3, 32'h8); tick(1);
    rd_chk("R6 pend bits left", 2'd2, 32'h202);
    tick(1);
    fetch_chk("R6 next winner src1", 32'h18, 32'h24);
    wr(2'd3, 32'h2); tick(1);
    fetch_chk("R8 src9 slot", 32'h18, 32'h4C);
    wr(2'd3, 32'h200);
    src = '0; tick(2);

    // R8: slots across group boundaries
    foreach (src[n]) begin
      if (n == 5 || n == 6 || n == 11 || n == 12 || n == 17 || n == 18 || n == 25) begin
        src[n] = 1'b1; tick(3);
        fetch_chk("R8 slot", 32'h18, slot_of(n));
        chk("R8 not reserved",
            {31'd0, (maddr == 32'h38 || maddr == 32'h3C || maddr == 32'h58 || maddr == 32'h5C)}, 32'd0);
        wr(2'd3, 32'd1 << n); src[n] = 1'b0; tick(2);
      end
    end
    fetch_chk("R8 src25 value", 32'h18, 32'h18);

    // R10: shared source held while busy
    busy = 1'b1; src[4] = 1'b1; tick(3);
    wr(2'd3, 32'h10); tick(1);
    rd_chk("R10 pend held", 2'd2, 32'h10);
    rd_chk("R10 srv held", 2'd3, 32'h10);
    busy = 1'b0;
    wr(2'd3, 32'h10); tick(1);
    rd_chk("R10 cleared after busy", 2'd3, 32'h0);
    src[4] = 1'b0; tick(2);

    // R11: edge beats clear
    src[2] = 1'b1; tick(3);
    src[2] = 1'b0; tick(1);
    src[2] = 1'b1;
    wr(2'd3, 32'h4); tick(1);
    rd_chk("R11 set wins", 2'd2, 32'h4);
    rd_chk("R11 rewon", 2'd3, 32'h4);
    wr(2'd3, 32'h4); src[2] = 1'b0; tick(2);

    // R3: masked source pending with nothing served
    wr(2'd1, 32'h1); src[0] = 1'b1; tick(3);
    rd_chk("R3 masked pend", 2'd2, 32'h1);
    chk("R3 masked irq low", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h0); tick(2);
    fetch_chk("R7 src0 slot", 32'h18, 32'h20);

    // R9: non-vectored mode passes through while in service
    wr(2'd0, 32'h0); tick(1);
    fetch_chk("R9 mode off", 32'h18, 32'h18);
    tick(3);
    finish_run();
  end
endmodule